// File: doc/BRIEF.md
# Queued-Sample Pulse-Width Modulator

This block drives one pulse-width modulated output from a free-running, prescaled period counter. Software reaches it through a small register bus with four word registers. It selects a prescale divider and a period length, then feeds duty values into a short queue. At the start of every output period the counter takes exactly one value from the queue. When the queue is empty, the last value is used again, so the waveform never stalls.

The output is high from the start of a period until the counter reaches the active duty value, and low for the rest of the period. A status register shows how many queued values are waiting and flags writes that were dropped because the queue was full. Writing the self-clearing reset bit flushes the queue and returns every register to its default. Software can poll that bit until the reset has finished.

Top module: `qpwm`

## Requirements
- R1: Register offsets: control 0x00, status 0x04, sample 0x0C, period 0x10. Control fields: bit 0 enable, bit 3 soft reset, bits [15:4] prescale value k, bits [17:16] clock-source code, bits [24:22] low-power run enables. The control and period registers read back what was written, and the control register's other bits read 0. After reset every register reads 0.
- R2: Writes to the sample register enter a 4-deep queue. Status bits [2:0] give the number of queued words, and a value of 4 means full.
- R3: A sample write while the queue is full is discarded and sets sticky status bit 4. Writing a 1 to status bit 4 clears it.
- R4: While enable is 0 the output stays low, the counter is held at its start, and no queued word is consumed.
- R5: One output period lasts (P+2)*(k+1) clock cycles, where P is the period register and k the prescale field.
- R6: In each period the output is high for D*(k+1) cycles from the period start, where D is the active duty value, and low for the rest of the period.
- R7: Exactly one queued word is taken at the start of each period, including the first period after enable, and the status count falls by one.
- R8: If the queue is empty at a period start, the previous duty value is kept for that period.
- R9: Writing control with bit 3 set makes bit 3 read 1 for exactly 4 cycles and then 0. After that, control, period and status (count and overflow) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all logic is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, 0 when bus_sel is low |
| pwm_out | output | 1 | Modulated output |

## Verification
A queue pointer or occupancy fault shows up first in the status count. It then appears in the output pulse widths, which follow the wrong sequence within one period, and a value skipped or repeated shifts every later pulse. A prescale or terminal-count fault changes the spacing between rising edges from the first period on. A fault in the soft-reset sequencer shows on the first poll of the control register, either as a reset bit that clears too early or too late, or as register contents that survive it.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;

    localparam int BUS_AW  = 5;
    localparam int BUS_DW  = 32;
    localparam int PRESC_W = 12;
    localparam int SRC_W   = 2;
    localparam int LP_W    = 3;

    localparam logic [BUS_AW-1:0] OFS_CTRL = 5'h00;
    localparam logic [BUS_AW-1:0] OFS_STAT = 5'h04;
    localparam logic [BUS_AW-1:0] OFS_SAMP = 5'h0C;
    localparam logic [BUS_AW-1:0] OFS_PER  = 5'h10;

    localparam int BIT_EN    = 0;
    localparam int BIT_SWR   = 3;
    localparam int PRESC_LSB = 4;
    localparam int SRC_LSB   = 16;
    localparam int LP_LSB    = 22;
    localparam int BIT_OVF   = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_SAMP,
        SEL_PER
    } reg_sel_e;

    typedef struct packed {
        logic [LP_W-1:0]    lp_run;
        logic [SRC_W-1:0]   clk_src;
        logic [PRESC_W-1:0] presc;
        logic               en;
    } ctrl_t;

    function automatic reg_sel_e decode_addr(input logic [BUS_AW-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CTRL: s = SEL_CTRL;
            OFS_STAT: s = SEL_STAT;
            OFS_SAMP: s = SEL_SAMP;
            OFS_PER:  s = SEL_PER;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [BUS_DW-1:0] w);
        ctrl_t c;
        c.en      = w[BIT_EN];
        c.presc   = w[PRESC_LSB +: PRESC_W];
        c.clk_src = w[SRC_LSB +: SRC_W];
        c.lp_run  = w[LP_LSB +: LP_W];
        return c;
    endfunction

    function automatic logic [BUS_DW-1:0] ctrl_to_word(input ctrl_t c, input logic swr);
        logic [BUS_DW-1:0] w;
        w = '0;
        w[BIT_EN]                = c.en;
        w[BIT_SWR]               = swr;
        w[PRESC_LSB +: PRESC_W]  = c.presc;
        w[SRC_LSB +: SRC_W]      = c.clk_src;
        w[LP_LSB +: LP_W]        = c.lp_run;
        return w;
    endfunction

endpackage

// File: rtl/qpwm_fifo.sv
module qpwm_fifo #(
    parameter  int DW    = 16,
    parameter  int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    pop_data,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full     = (count == CNT_FULL);
    assign empty    = (count == '0);
    assign push_ok  = push && !full;
    assign pop_ok   = pop && !empty;
    assign pop_data = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // R2: occupancy never exceeds the queue depth
    assert_fifo_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_FULL);

    // R3: a push into a full queue never adds a word
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (push && full && !flush) |=> (count == $past(count) - CNT_W'($past(pop))));

endmodule

// File: rtl/qpwm_counter.sv
module qpwm_counter #(
    parameter  int DW      = 16,
    parameter  int PRESC_W = 12,
    localparam int CW      = DW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic               en,
    input  logic [PRESC_W-1:0] presc,
    input  logic [DW-1:0]      period,
    input  logic               fifo_empty,
    input  logic [DW-1:0]      fifo_data,
    output logic               pop,
    output logic [DW-1:0]      active,
    output logic               pwm_out
);

    logic               started;
    logic [PRESC_W-1:0] pre_q;
    logic [CW-1:0]      cnt_q;
    logic [CW-1:0]      last_cnt;
    logic               tick, wrap, load;

    assign last_cnt = {1'b0, period} + CW'(1);
    assign tick     = (pre_q >= presc);
    assign wrap     = started && tick && (cnt_q >= last_cnt);
    assign load     = en && (!started || wrap);
    assign pop      = load && !fifo_empty;
    assign pwm_out  = en && started && ({1'b0, active} > cnt_q);

    always_ff @(posedge clk) begin
        if (rst || soft_rst || !en) begin
            started <= 1'b0;
            pre_q   <= '0;
            cnt_q   <= '0;
        end else if (!started) begin
            started <= 1'b1;
            pre_q   <= '0;
            cnt_q   <= '0;
        end else if (tick) begin
            pre_q <= '0;
            cnt_q <= wrap ? '0 : cnt_q + CW'(1);
        end else begin
            pre_q <= pre_q + PRESC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            active <= '0;
        end else if (pop) begin
            active <= fifo_data;
        end
    end

    // R4: a disabled counter sits at its start position
    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0 && pre_q == '0));

    // R7: consecutive period starts are at least two cycles apart
    assert_one_pop_R7: assert property (@(posedge clk) disable iff (rst)
        pop |=> !pop);

endmodule

// File: rtl/qpwm_regs.sv
module qpwm_regs
    import qpwm_pkg::*;
#(
    parameter  int DW         = 16,
    parameter  int CNT_W      = 3,
    parameter  int SWR_CYCLES = 4,
    localparam int SWR_W      = $clog2(SWR_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] wdata,
    input  logic              fifo_full,
    input  logic [CNT_W-1:0]  fifo_cnt,
    input  logic [DW-1:0]     active,
    output ctrl_t             ctrl,
    output logic [DW-1:0]     period,
    output logic              push,
    output logic [DW-1:0]     push_data,
    output logic              flush,
    output logic              busy,
    output logic [BUS_DW-1:0] rdata
);

    reg_sel_e         sel;
    logic [SWR_W-1:0] swr_cnt;
    logic             ovf_q;
    logic             wr_ok, ovf_clr;

    assign sel       = decode_addr(addr);
    assign busy      = (swr_cnt != '0);
    assign wr_ok     = wr && !busy;
    assign flush     = wr_ok && (sel == SEL_CTRL) && wdata[BIT_SWR];
    assign push      = wr_ok && (sel == SEL_SAMP);
    assign push_data = wdata[DW-1:0];
    assign ovf_clr   = wr_ok && (sel == SEL_STAT) && wdata[BIT_OVF];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            period  <= '0;
            ovf_q   <= 1'b0;
            swr_cnt <= '0;
        end else if (flush) begin
            ctrl    <= '0;
            period  <= '0;
            ovf_q   <= 1'b0;
            swr_cnt <= SWR_W'(SWR_CYCLES);
        end else begin
            if (busy) swr_cnt <= swr_cnt - SWR_W'(1);
            if (wr_ok && sel == SEL_CTRL) ctrl   <= ctrl_from_word(wdata);
            if (wr_ok && sel == SEL_PER)  period <= wdata[DW-1:0];
            if (push && fifo_full)        ovf_q  <= 1'b1;
            else if (ovf_clr)             ovf_q  <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL: rdata = ctrl_to_word(ctrl, busy);
            SEL_STAT: begin
                rdata[CNT_W-1:0] = fifo_cnt;
                rdata[BIT_OVF]   = ovf_q;
            end
            SEL_SAMP: rdata[DW-1:0] = active;
            SEL_PER:  rdata[DW-1:0] = period;
            default:  rdata = '0;
        endcase
    end

    // R9: the reset bit stays visible for the full sequence length
    assert_swr_len_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(busy, SWR_CYCLES));

    // R9: control stays at its default while the sequence runs
    assert_swr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ctrl == '0 && period == '0));

    // R3: the overflow flag only drops on an explicit clear
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !ovf_clr && !flush) |=> ovf_q);

endmodule

// File: rtl/qpwm.sv
module qpwm
    import qpwm_pkg::*;
#(
    parameter  int DW         = 16,
    parameter  int DEPTH      = 4,
    parameter  int SWR_CYCLES = 4,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              pwm_out
);

    ctrl_t             ctrl;
    logic [DW-1:0]     period, push_data, pop_data, active;
    logic              push, pop, flush, busy;
    logic              fifo_full, fifo_empty;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [BUS_DW-1:0] reg_rdata;

    assign bus_rdata = bus_sel ? reg_rdata : '0;

    qpwm_regs #(
        .DW(DW), .CNT_W(CNT_W), .SWR_CYCLES(SWR_CYCLES)
    ) u_regs (
        .clk(clk), .rst(rst),
        .wr(bus_sel && bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .fifo_full(fifo_full), .fifo_cnt(fifo_cnt), .active(active),
        .ctrl(ctrl), .period(period),
        .push(push), .push_data(push_data),
        .flush(flush), .busy(busy), .rdata(reg_rdata)
    );

    qpwm_fifo #(
        .DW(DW), .DEPTH(DEPTH)
    ) u_fifo (
        .clk(clk), .rst(rst), .flush(flush),
        .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pop_data),
        .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
    );

    qpwm_counter #(
        .DW(DW), .PRESC_W(PRESC_W)
    ) u_counter (
        .clk(clk), .rst(rst), .soft_rst(flush),
        .en(ctrl.en), .presc(ctrl.presc), .period(period),
        .fifo_empty(fifo_empty), .fifo_data(pop_data),
        .pop(pop), .active(active), .pwm_out(pwm_out)
    );

    // R9: the queue is empty when the reset sequence ends
    assert_swr_flush_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (fifo_cnt == '0));

    // R4: a disabled block never drains its queue
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !flush) |=> (fifo_cnt >= $past(fifo_cnt)));

endmodule

// File: tb/qpwm_tb.sv
module qpwm_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_we;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int exp_q[$];
    int exp_period = 0;
    bit mon_en     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qpwm u_dut (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic expect_reg(input logic [4:0] a, input logic [31:0] e, input string tag);
        logic [31:0] v;
        bus_read(a, v);
        check(v == e, tag, v, e);
    endtask

    // monitor: pulse widths against the scoreboard, spacing against exp_period
    bit prev = 1'b0;
    bit seen_rise = 1'b0;
    int hi_run = 0;
    int per_cnt = 0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (pwm_out) hi_run++;
            if (pwm_out && !prev) begin
                if (seen_rise) check(per_cnt == exp_period, "R5 period length", per_cnt, exp_period);
                seen_rise = 1'b1;
                per_cnt = 1;
            end else begin
                per_cnt++;
            end
            if (!pwm_out && prev) begin
                if (exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    check(hi_run == e, "R6/R7/R8 high time", hi_run, e);
                end
                hi_run = 0;
            end
        end else begin
            hi_run = 0;
            per_cnt = 0;
            seen_rise = 1'b0;
        end
        prev = pwm_out;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int lowbad;
        bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_reg(5'h00, 32'h0, "R1 ctrl reset");
        expect_reg(5'h04, 32'h0, "R1 status reset");
        expect_reg(5'h10, 32'h0, "R1 period reset");
        check(pwm_out == 1'b0, "R1 output reset", pwm_out, 0);

        // R1 field readback: k=1, source 2, all run enables, disabled
        bus_write(5'h10, 32'd6);
        bus_write(5'h00, 32'h01C2_0010);
        expect_reg(5'h00, 32'h01C2_0010, "R1 ctrl readback");
        expect_reg(5'h10, 32'd6, "R1 period readback");

        // R2 queue fill with occupancy
        bus_write(5'h0C, 32'd2); expect_reg(5'h04, 32'd1, "R2 count 1");
        bus_write(5'h0C, 32'd5); expect_reg(5'h04, 32'd2, "R2 count 2");
        bus_write(5'h0C, 32'd3); expect_reg(5'h04, 32'd3, "R2 count 3");
        bus_write(5'h0C, 32'd1); expect_reg(5'h04, 32'd4, "R2 count full");

        // R3 overflow drop and clear
        bus_write(5'h0C, 32'd7); expect_reg(5'h04, 32'h14, "R3 overflow set");
        bus_write(5'h04, 32'h10); expect_reg(5'h04, 32'h04, "R3 overflow cleared");

        // R4 disabled: output low, nothing drained
        lowbad = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (pwm_out) lowbad++;
        end
        check(lowbad == 0, "R4 output low while disabled", lowbad, 0);
        expect_reg(5'h04, 32'd4, "R4 queue kept while disabled");

        // R5..R8 run: k=1, P=6 -> period 16, widths 2*D, last value reused
        exp_period = 16;
        exp_q.push_back(4); exp_q.push_back(10); exp_q.push_back(6);
        exp_q.push_back(2); exp_q.push_back(2); exp_q.push_back(2);
        mon_en = 1'b1;
        bus_write(5'h00, 32'h01C2_0011);
        @(posedge clk);
        expect_reg(5'h04, 32'd3, "R7 first word taken at enable");
        repeat (120) @(posedge clk);
        expect_reg(5'h04, 32'd0, "R7 queue drained one per period");
        expect_reg(5'h0C, 32'd1, "R8 last duty kept");
        check(exp_q.size() == 0, "R8 reused pulses seen", exp_q.size(), 0);
        mon_en = 1'b0;
        bus_write(5'h00, 32'h0);
        lowbad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pwm_out) lowbad++;
        end
        check(lowbad == 0, "R4 output low after disable", lowbad, 0);

        // R5/R6 second pattern: k=0, P=3 -> period 5
        bus_write(5'h10, 32'd3);
        bus_write(5'h0C, 32'd4);
        bus_write(5'h0C, 32'd2);
        exp_period = 5;
        exp_q.push_back(4); exp_q.push_back(2); exp_q.push_back(2);
        mon_en = 1'b1;
        bus_write(5'h00, 32'h1);
        repeat (40) @(posedge clk);
        check(exp_q.size() == 0, "R6 second pattern pulses seen", exp_q.size(), 0);
        mon_en = 1'b0;

        // R9 soft reset
        bus_write(5'h10, 32'd9);
        for (int i = 0; i < 5; i++) bus_write(5'h0C, 32'd3);
        expect_reg(5'h04, 32'h14, "R9 setup full with overflow");
        bus_write(5'h00, 32'h0000_0009);
        for (int i = 0; i < 4; i++) expect_reg(5'h00, 32'h8, "R9 reset bit held");
        expect_reg(5'h00, 32'h0, "R9 reset bit cleared");
        expect_reg(5'h04, 32'h0, "R9 queue and flag cleared");
        expect_reg(5'h10, 32'h0, "R9 period cleared");
        check(pwm_out == 1'b0, "R9 output idle", pwm_out, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule